// File: doc/BRIEF.md
# Temperature-indexed cache configuration selector

This block chooses the geometry of a configurable cache from the die temperature, once before each program run. When asked to start a run, it requests one reading from a digital thermal sensor and rounds the reading up to the next temperature point, 0 to 100 °C in 20 °C steps. It uses that point as the index into a small writable table and registers the selected entry. It then offers the entry to the cache on a valid/ready channel. Execution is enabled only after the cache has taken the word. If the sensor does not answer within a bounded wait, the hottest entry is used. That entry is the safe worst-case choice.

A host fills the table before runs start, over a valid/ready write channel. The selector never stalls this channel: `wr_ready` is high whenever no selection is in progress. A word offered while `wr_ready` is low is dropped and not held, so the host must offer it again. On the configuration channel the cache applies back-pressure by holding `cfg_ready` low. The selector then keeps `cfg_valid` high and `cfg_data` unchanged until a cycle in which both are high. The word stays on `cfg_data` for the whole run that follows.

Top module: `temp_cfg_selector`

## Requirements
- R1: During and right after reset, `start_en`, `sense_req` and `cfg_valid` are low, `wr_ready` is high and `cfg_data` equals the parameter `RESET_WORD`. Every table entry also resets to `RESET_WORD`.
- R2: A `run_req` seen while the selector is idle or running drops `start_en` and raises `sense_req` on the next cycle.
- R3: A reading of 0 selects entry 0. Otherwise the reading T selects entry ceil(T/`BIN_STEP`), capped at `NUM_BINS`-1. With the defaults, 1..20 selects entry 1, 81..100 selects entry 5, and anything above 100 also selects entry 5. The entry index is the same index the host uses in `wr_idx`.
- R4: If `sense_valid` is not seen within `TIMEOUT` cycles of raised `sense_req`, the selector drops `sense_req` and uses entry `NUM_BINS`-1.
- R5: `cfg_valid` rises two cycles after the cycle in which `sense_valid` is sampled. `cfg_data` carries the selected table entry. While `cfg_ready` is low, `cfg_valid` and `cfg_data` hold. The word layout is bits [5:4] size code, bits [3:2] line-size code and bits [1:0] way-count code.
- R6: `start_en` rises only in the cycle after a cycle in which `cfg_valid` and `cfg_ready` are both high. It is never high together with `sense_req` or `cfg_valid`.
- R7: While `start_en` is high, `cfg_data` does not change, even when the host rewrites the table entry in use.
- R8: With `wr_ready` high, a write to an index below `NUM_BINS` is stored. A write to a higher index has no effect. During selection `wr_ready` is low and offered writes are discarded.
- R9: A `run_req` raised while a selection is in progress is ignored.
- R10: `sense_req` stays high until `sense_valid` is sampled and drops in the following cycle. The reading on `sense_temp` is taken only in a cycle with `sense_req` and `sense_valid` both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_req | input | 1 | Request a new selection before a program run |
| start_en | output | 1 | Program execution may proceed |
| sense_req | output | 1 | Thermal sensor read request |
| sense_valid | input | 1 | Sensor reading present on sense_temp |
| sense_temp | input | TEMP_W | Sensor reading in °C, unsigned |
| wr_valid | input | 1 | Host offers a table write |
| wr_ready | output | 1 | Table write accepted this cycle |
| wr_idx | input | IDX_W | Table entry index (temperature bin) |
| wr_data | input | GEOM_W | Configuration word to store |
| cfg_valid | output | 1 | Configuration word offered to the cache |
| cfg_ready | input | 1 | Cache accepts the offered word |
| cfg_data | output | GEOM_W | Selected configuration word |

## Verification
The bench keeps the default bin layout: six entries, 20 °C step, 8-bit reading. This places readings exactly on, just above and far above the points, up to 250 °C. It builds the block with `TIMEOUT` = 10, so the sensor fallback is reached in a dozen cycles. With that value the bench can count exactly the cycle in which `sense_req` drops. Cache back-pressure of several cycles is combined with host writes and run requests offered during selection. This shows that the discarded writes are absent in the word issued by a later run.

// File: rtl/tcs_pkg.sv
package tcs_pkg;

  localparam int SIZE_W = 2;
  localparam int LINE_W = 2;
  localparam int WAY_W  = 2;

  typedef struct packed {
    logic [SIZE_W-1:0] size_code;
    logic [LINE_W-1:0] line_code;
    logic [WAY_W-1:0]  way_code;
  } geom_t;

  localparam int GEOM_W = $bits(geom_t);

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SENSE,
    PH_LOOKUP,
    PH_APPLY,
    PH_RUN
  } phase_t;

endpackage

// File: rtl/tcs_binner.sv
module tcs_binner #(
  parameter int TEMP_W   = 8,
  parameter int NUM_BINS = 6,
  parameter int BIN_STEP = 20,
  parameter int IDX_W    = 3
) (
  input  logic [TEMP_W-1:0] temp,
  output logic [IDX_W-1:0]  bin
);

  localparam int NTHR = NUM_BINS - 1;

  // one comparator per threshold; the count of exceeded thresholds is the
  // rounded-up bin, which caps naturally at the last entry
  logic [NTHR-1:0] above;

  for (genvar g = 0; g < NTHR; g++) begin : g_thr
    localparam logic [TEMP_W:0] THR = (TEMP_W+1)'(g * BIN_STEP);
    assign above[g] = ({1'b0, temp} > THR);
  end

  always_comb begin
    bin = IDX_W'($countones(above));
  end

endmodule

// File: rtl/tcs_table.sv
module tcs_table #(
  parameter int NUM_BINS = 6,
  parameter int IDX_W    = 3,
  parameter int GEOM_W   = 6,
  parameter logic [GEOM_W-1:0] RESET_WORD = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  widx,
  input  logic [GEOM_W-1:0] wdata,
  input  logic [IDX_W-1:0]  ridx,
  output logic [GEOM_W-1:0] rdata
);

  logic [GEOM_W-1:0] mem [NUM_BINS];

  always_ff @(posedge clk) begin
    for (int e = 0; e < NUM_BINS; e++) begin
      if (!rst_n) begin
        mem[e] <= RESET_WORD;
      end else if (we && (int'(widx) == e)) begin
        mem[e] <= wdata;
      end
    end
  end

  always_comb begin
    if (int'(ridx) < NUM_BINS) rdata = mem[ridx];
    else                       rdata = mem[NUM_BINS-1];
  end

  for (genvar g = 0; g < NUM_BINS; g++) begin : g_chk
    AST_ENTRY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(we && (int'(widx) == g)) |=> $stable(mem[g])); // R8
  end

endmodule

// File: rtl/tcs_seq.sv
module tcs_seq
  import tcs_pkg::*;
#(
  parameter int TIMEOUT  = 64,
  parameter int NUM_BINS = 6,
  parameter int IDX_W    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_req,
  input  logic             sense_valid,
  input  logic [IDX_W-1:0] sense_bin,
  input  logic             cfg_ready,
  output logic             sense_req,
  output logic [IDX_W-1:0] sel_bin,
  output logic             load_en,
  output logic             cfg_valid,
  output logic             start_en,
  output logic             busy
);

  localparam int CNT_W = $clog2(TIMEOUT + 1);
  localparam logic [IDX_W-1:0] HOT_BIN = IDX_W'(NUM_BINS - 1);
  localparam logic [CNT_W-1:0] LAST_WAIT = CNT_W'(TIMEOUT - 1);

  phase_t            ph;
  logic [CNT_W-1:0]  wait_cnt;
  logic [IDX_W-1:0]  bin_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph       <= PH_IDLE;
      wait_cnt <= '0;
      bin_q    <= HOT_BIN;
    end else begin
      unique case (ph)
        PH_IDLE, PH_RUN: begin
          if (run_req) begin
            ph       <= PH_SENSE;
            wait_cnt <= '0;
          end
        end
        PH_SENSE: begin
          if (sense_valid) begin
            bin_q <= sense_bin;
            ph    <= PH_LOOKUP;
          end else if (wait_cnt == LAST_WAIT) begin
            bin_q <= HOT_BIN;
            ph    <= PH_LOOKUP;
          end else begin
            wait_cnt <= wait_cnt + CNT_W'(1);
          end
        end
        PH_LOOKUP: ph <= PH_APPLY;
        PH_APPLY: if (cfg_ready) ph <= PH_RUN;
        default: ph <= PH_IDLE;
      endcase
    end
  end

  assign sense_req = (ph == PH_SENSE);
  assign load_en   = (ph == PH_LOOKUP);
  assign cfg_valid = (ph == PH_APPLY);
  assign start_en  = (ph == PH_RUN);
  assign busy      = (ph == PH_SENSE) || (ph == PH_LOOKUP) || (ph == PH_APPLY);
  assign sel_bin   = bin_q;

  AST_WAIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    sense_req |-> (wait_cnt < CNT_W'(TIMEOUT))); // R4
  AST_FALLBACK_HOT: assert property (@(posedge clk) disable iff (!rst_n)
    (sense_req && !sense_valid && wait_cnt == LAST_WAIT) |=> (!sense_req && sel_bin == HOT_BIN)); // R4
  AST_SENSE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (sense_req && sense_valid) |=> !sense_req); // R10
  AST_BUSY_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !sense_req) |=> !sense_req); // R9

endmodule

// File: rtl/temp_cfg_selector.sv
module temp_cfg_selector
  import tcs_pkg::*;
#(
  parameter int TEMP_W   = 8,
  parameter int NUM_BINS = 6,
  parameter int BIN_STEP = 20,
  parameter int TIMEOUT  = 64,
  parameter logic [GEOM_W-1:0] RESET_WORD = '0,
  localparam int IDX_W   = $clog2(NUM_BINS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_req,
  output logic              start_en,
  output logic              sense_req,
  input  logic              sense_valid,
  input  logic [TEMP_W-1:0] sense_temp,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [GEOM_W-1:0] wr_data,
  output logic              cfg_valid,
  input  logic              cfg_ready,
  output logic [GEOM_W-1:0] cfg_data
);

  logic [IDX_W-1:0]  meas_bin;
  logic [IDX_W-1:0]  sel_bin;
  logic              load_en;
  logic              busy;
  logic              tbl_we;
  logic [GEOM_W-1:0] tbl_word;
  geom_t             issue_q;

  tcs_binner #(
    .TEMP_W  (TEMP_W),
    .NUM_BINS(NUM_BINS),
    .BIN_STEP(BIN_STEP),
    .IDX_W   (IDX_W)
  ) u_binner (
    .temp(sense_temp),
    .bin (meas_bin)
  );

  tcs_seq #(
    .TIMEOUT (TIMEOUT),
    .NUM_BINS(NUM_BINS),
    .IDX_W   (IDX_W)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_req    (run_req),
    .sense_valid(sense_valid),
    .sense_bin  (meas_bin),
    .cfg_ready  (cfg_ready),
    .sense_req  (sense_req),
    .sel_bin    (sel_bin),
    .load_en    (load_en),
    .cfg_valid  (cfg_valid),
    .start_en   (start_en),
    .busy       (busy)
  );

  assign wr_ready = !busy;
  assign tbl_we   = wr_valid && wr_ready && (int'(wr_idx) < NUM_BINS);

  tcs_table #(
    .NUM_BINS  (NUM_BINS),
    .IDX_W     (IDX_W),
    .GEOM_W    (GEOM_W),
    .RESET_WORD(RESET_WORD)
  ) u_table (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (tbl_we),
    .widx (wr_idx),
    .wdata(wr_data),
    .ridx (sel_bin),
    .rdata(tbl_word)
  );

  // issue register: captured once per selection, held through the run
  always_ff @(posedge clk) begin
    if (!rst_n)       issue_q <= geom_t'(RESET_WORD);
    else if (load_en) issue_q <= geom_t'(tbl_word);
  end

  assign cfg_data = issue_q;

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && !cfg_ready) |=> (cfg_valid && $stable(cfg_data))); // R5
  AST_START_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(start_en) |-> $past(cfg_valid && cfg_ready)); // R6
  AST_PHASE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sense_req, cfg_valid, start_en})); // R6
  AST_RUN_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (start_en && $past(start_en)) |-> $stable(cfg_data)); // R7
  AST_WR_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (sense_req || cfg_valid) |-> !wr_ready); // R8

endmodule

// File: tb/test_temp_cfg_selector.sv
module test_temp_cfg_selector;

  localparam int TW   = 8;
  localparam int NB   = 6;
  localparam int STEP = 20;
  localparam int TO   = 10;
  localparam int IW   = 3;
  localparam int GW   = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          run_req = 0, start_en, sense_req, sense_valid = 0;
  logic [TW-1:0] sense_temp = '0;
  logic          wr_valid = 0, wr_ready;
  logic [IW-1:0] wr_idx = '0;
  logic [GW-1:0] wr_data = '0;
  logic          cfg_valid, cfg_ready = 0;
  logic [GW-1:0] cfg_data;

  temp_cfg_selector #(
    .TEMP_W(TW), .NUM_BINS(NB), .BIN_STEP(STEP), .TIMEOUT(TO)
  ) i_temp_cfg_selector (
    .clk(clk), .rst_n(rst_n), .run_req(run_req), .start_en(start_en),
    .sense_req(sense_req), .sense_valid(sense_valid), .sense_temp(sense_temp),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_idx(wr_idx), .wr_data(wr_data),
    .cfg_valid(cfg_valid), .cfg_ready(cfg_ready), .cfg_data(cfg_data)
  );

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;
  logic [GW-1:0] mdl [NB];
  logic [GW-1:0] exp_q [$];
  logic [GW-1:0] mon_e;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int bin_of(input int t);
    int b = 0;
    for (int k = 0; k < NB - 1; k++) if (t > k * STEP) b++;
    return b;
  endfunction

  // scoreboard monitor: every accepted configuration word is compared
  always @(negedge clk) begin
    #1;
    if (rst_n && cfg_valid && cfg_ready) begin
      if (exp_q.size() == 0) begin
        chk(0, "R5 unexpected issued word", int'(cfg_data), 0);
      end else begin
        mon_e = exp_q.pop_front();
        chk(cfg_data == mon_e, "R5 issued word", int'(cfg_data), int'(mon_e));
      end
    end
  end

  task automatic host_write(input int idx, input int data, input bit expect_ok);
    @(negedge clk);
    chk(wr_ready == expect_ok, "R8 wr_ready level", int'(wr_ready), int'(expect_ok));
    wr_valid = 1; wr_idx = IW'(idx); wr_data = GW'(data);
    if (expect_ok && idx < NB) mdl[idx] = GW'(data);
    @(negedge clk);
    wr_valid = 0;
  endtask

  task automatic do_run(input int temp, input bit tmo, input int resp_dly,
                        input int ack_dly, input bit poke);
    int b;
    b = tmo ? NB - 1 : bin_of(temp);
    @(negedge clk);
    run_req = 1;
    @(negedge clk);
    run_req = 0;
    chk(sense_req == 1, "R2 sense_req after run_req", int'(sense_req), 1);
    chk(start_en == 0, "R2 start_en dropped", int'(start_en), 0);
    if (tmo) begin
      for (int k = 1; k < TO; k++) @(negedge clk);
      chk(sense_req == 1, "R4 still waiting at last cycle", int'(sense_req), 1);
      @(negedge clk);
      chk(sense_req == 0, "R4 timeout releases request", int'(sense_req), 0);
    end else begin
      for (int k = 0; k < resp_dly; k++) begin
        @(negedge clk);
        chk(sense_req == 1, "R10 request held", int'(sense_req), 1);
      end
      sense_valid = 1; sense_temp = TW'(temp);
      @(negedge clk);
      sense_valid = 0; sense_temp = 8'hFF;
      chk(sense_req == 0, "R10 request drops after reading", int'(sense_req), 0);
    end
    exp_q.push_back(mdl[b]);
    @(negedge clk);
    chk(cfg_valid == 1, "R5 cfg_valid two cycles after reading", int'(cfg_valid), 1);
    chk(cfg_data == mdl[b], tmo ? "R4 fallback entry" : "R3 entry for reading",
        int'(cfg_data), int'(mdl[b]));
    if (poke) begin
      wr_valid = 1; wr_idx = IW'(b); wr_data = ~mdl[b]; run_req = 1;
      chk(wr_ready == 0, "R8 wr_ready low while selecting", int'(wr_ready), 0);
    end
    for (int k = 0; k < ack_dly; k++) begin
      @(negedge clk);
      chk(cfg_valid == 1 && cfg_data == mdl[b], "R5 word held under back-pressure",
          int'(cfg_data), int'(mdl[b]));
      chk(start_en == 0, "R6 no start before acceptance", int'(start_en), 0);
    end
    wr_valid = 0; run_req = 0;
    cfg_ready = 1;
    @(negedge clk);
    cfg_ready = 0;
    chk(start_en == 1, "R6 start after acceptance", int'(start_en), 1);
    chk(cfg_valid == 0, "R6 cfg_valid dropped", int'(cfg_valid), 0);
    @(negedge clk);
    chk(sense_req == 0 && start_en == 1, "R9 run_req during selection ignored",
        int'(sense_req), 0);
    chk(cfg_data == mdl[b], "R7 word kept during run", int'(cfg_data), int'(mdl[b]));
  endtask

  initial begin
    for (int e = 0; e < NB; e++) mdl[e] = '0;
    repeat (3) @(negedge clk);
    chk(start_en == 0 && sense_req == 0 && cfg_valid == 0, "R1 outputs in reset",
        int'({start_en, sense_req, cfg_valid}), 0);
    rst_n = 1;
    @(negedge clk);
    chk(wr_ready == 1, "R1 wr_ready after reset", int'(wr_ready), 1);
    chk(cfg_data == '0, "R1 cfg_data reset word", int'(cfg_data), 0);

    do_run(50, 0, 0, 0, 0);                       // R1 table reset contents
    for (int e = 0; e < NB; e++) host_write(e, (e * 11 + 7) % 64, 1);
    host_write(6, 63, 1);                         // R8 out-of-range index

    do_run(0, 0, 0, 0, 0);
    do_run(20, 0, 2, 1, 0);
    do_run(21, 0, 1, 3, 1);
    do_run(55, 0, 3, 0, 0);
    do_run(80, 0, 0, 2, 1);
    do_run(81, 0, 1, 1, 0);
    do_run(100, 0, 0, 4, 0);
    do_run(250, 0, 2, 0, 0);
    do_run(0, 1, 0, 2, 1);                        // R4 sensor silent

    do_run(55, 0, 1, 1, 0);
    host_write(3, 42, 1);                         // R7 rewrite entry in use
    @(negedge clk);
    chk(cfg_data == GW'((3 * 11 + 7) % 64), "R7 running word unchanged",
        int'(cfg_data), (3 * 11 + 7) % 64);
    do_run(41, 0, 0, 1, 0);                       // sees the new word
    do_run(21, 0, 0, 0, 0);                       // R8 poked write discarded
    do_run(1, 0, 0, 0, 0);

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R5 all words issued", exp_q.size(), 0);
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    #800000;
    if (!done) begin
      done = 1;
      chk(0, "watchdog expired", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

endmodule